// File: doc/BRIEF.md
# Low-Resolution Raster Timing and Pixel Stream Generator

This block produces the raster timing for a small, non-standard monitor mode that runs from a 12 MHz pixel clock. A line lasts 381 clocks and shows 256 pixels. A frame has 528 lines, of which 480 are shown. The block drives registered, active-low horizontal and vertical sync. It also drives a blanking flag that is delayed by one register, so that it lines up with the colour stage that follows. Each sync edge is placed so that it allows for a two-clock delay between the counters and the pixel on screen.

Video memory supplies one byte for every four visible pixels. Each byte packs four 2-bit pixel codes. The block takes a byte from its memory data input at the start of every group of four visible pixels. It presents the low two bits first, then shifts the byte right by two on each following visible clock. While the delayed blanking flag is high, the pixel code is held at zero. Memory addressing and colour lookup sit outside this block.

Top module: `vga_stream_gen`

## Requirements
- R1: The pixel counter steps once per clock from 0 to H_TOTAL-1 (380 by default) and then returns to 0, so a line is H_TOTAL clocks long.
- R2: `hsync_n` is low in the clocks that follow an edge where the pixel count lies in [HS_START, HS_END) (291 to 336 by default). It is therefore low for HS_END-HS_START clocks (46) and high otherwise.
- R3: The line counter advances once per line, at the edge where the pixel count moves from H_VIS-1 to H_VIS (the start of horizontal blanking). It wraps from V_TOTAL-1 (527) to 0, so a frame lasts H_TOTAL*V_TOTAL clocks.
- R4: `vsync_n` is updated at line-advance edges only. At such an edge it goes low if the line count before the edge lies in [VS_START, VS_END) (493 to 494), and high otherwise. It is therefore low for VS_END-VS_START lines (2).
- R5: The undelayed blanking condition is true when the pixel count is H_VIS (256) or more, or when the line count is V_VIS (480) or more.
- R6: `blank` equals the blanking condition of the previous clock.
- R7: While `rst_n` is low at a clock edge, both counters clear to 0, `hsync_n` and `vsync_n` go high, `blank` goes high and the pixel byte clears to 0.
- R8: At a non-blanked clock edge where the pixel count is a multiple of 4, the byte on `ram_data` is captured. At the other non-blanked edges the held byte shifts right by 2. `pix_code` shows bits [1:0] of the held byte.
- R9: While `blank` is high, `pix_code` is 0, and `ram_data` presented at blanked edges does not change the held byte.
- R10: Between line-advance edges, `vsync_n` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset, used at start-up |
| ram_data | input | BYTE_W (8) | Byte from video memory, four packed 2-bit pixels |
| hsync_n | output | 1 | Registered active-low horizontal sync |
| vsync_n | output | 1 | Registered active-low vertical sync |
| blank | output | 1 | Blanking flag, delayed by one clock |
| pix_code | output | PIX_BITS (2) | Current pixel code, zero while blanked |

## Verification
Every output is one register away from the counter state at the preceding edge. The sync outputs, `blank` and the newly loaded or shifted pixel byte are all due one edge after the counter value that causes them. A loaded byte's first code appears on `pix_code` one edge after capture, aligned with `blank` falling. The bench drives inputs on the falling edge. It advances a reference state by one step for each rising edge, using only the rules in the requirements. It then compares every output on the next falling edge, so each result is sampled in the cycle it is due. Pulse widths and the sync periods are also measured by counting cycles between the observed edges.

// File: rtl/vga_pkg.sv
// Shared definitions for the raster timing generator.
// Assumes: pixel width divides the memory byte width evenly.
package vga_pkg;

    // Action applied to the packed pixel byte on a clock edge.
    typedef enum logic [1:0] {
        PIX_HOLD  = 2'd0,
        PIX_LOAD  = 2'd1,
        PIX_SHIFT = 2'd2
    } pix_act_e;

endpackage

// File: rtl/vga_hcount.sv
// Horizontal pixel counter.
// Counts 0..H_TOTAL-1 and wraps. Flags the last visible pixel, which the
// line counter uses as its advance enable, and the horizontal blank region.
// Assumes: H_VIS < H_TOTAL; synchronous active-low reset.
module vga_hcount #(
    parameter int H_TOTAL = 381,
    parameter int H_VIS   = 256,
    parameter int HW      = $clog2(H_TOTAL)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [HW-1:0] hcnt,
    output logic          line_adv,
    output logic          h_blank
);
    localparam logic [HW-1:0] H_LAST     = HW'(H_TOTAL - 1);
    localparam logic [HW-1:0] H_VIS_LAST = HW'(H_VIS - 1);
    localparam logic [HW-1:0] H_VIS_END  = HW'(H_VIS);

    // Step the pixel count, wrapping at the end of the line.
    always_ff @(posedge clk) begin
        if (!rst_n)              hcnt <= '0;
        else if (hcnt == H_LAST) hcnt <= '0;
        else                     hcnt <= hcnt + 1'b1;
    end

    // Decode the line-advance point and the horizontal blank region.
    always_comb begin
        line_adv = (hcnt == H_VIS_LAST);
        h_blank  = (hcnt >= H_VIS_END);
    end
endmodule

// File: rtl/vga_vcount.sv
// Vertical line counter.
// Runs on the pixel clock and advances only when line_adv is high, which
// happens once per line as horizontal blanking begins. Wraps at V_TOTAL.
// Assumes: V_VIS < V_TOTAL; synchronous active-low reset.
module vga_vcount #(
    parameter int V_TOTAL = 528,
    parameter int V_VIS   = 480,
    parameter int VW      = $clog2(V_TOTAL)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_adv,
    output logic [VW-1:0] vcnt,
    output logic          v_blank
);
    localparam logic [VW-1:0] V_LAST    = VW'(V_TOTAL - 1);
    localparam logic [VW-1:0] V_VIS_END = VW'(V_VIS);

    // Advance the line count at each line-end enable, wrapping per frame.
    always_ff @(posedge clk) begin
        if (!rst_n)             vcnt <= '0;
        else if (line_adv) begin
            if (vcnt == V_LAST) vcnt <= '0;
            else                vcnt <= vcnt + 1'b1;
        end
    end

    // Flag the lines below the visible area.
    always_comb v_blank = (vcnt >= V_VIS_END);
endmodule

// File: rtl/vga_sync_reg.sv
// Registered active-low sync pulse.
// On each enabled edge, the output goes low if the count lies in
// [START, STOP) and goes high otherwise. The output is high after reset.
// Assumes: START < STOP and both fit in W bits.
module vga_sync_reg #(
    parameter int W     = 9,
    parameter int START = 291,
    parameter int STOP  = 337
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_en,
    input  logic [W-1:0] cnt,
    output logic         sync_n
);
    localparam logic [W-1:0] S_LO = W'(START);
    localparam logic [W-1:0] S_HI = W'(STOP);

    logic in_pulse;

    // Decide whether the count lies inside the pulse window.
    always_comb in_pulse = (cnt >= S_LO) && (cnt < S_HI);

    // Register the active-low sync level on enabled edges.
    always_ff @(posedge clk) begin
        if (!rst_n)       sync_n <= 1'b1;
        else if (step_en) sync_n <= ~in_pulse;
    end
endmodule

// File: rtl/vga_pix_shift.sv
// Packed pixel byte register.
// Loads a memory byte, shifts it right by one pixel width, or holds it,
// as the action input selects. The current pixel is taken from the low bits.
// Assumes: BYTE_W is a multiple of PIX_BITS.
module vga_pix_shift
    import vga_pkg::*;
#(
    parameter int BYTE_W   = 8,
    parameter int PIX_BITS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  pix_act_e            act,
    input  logic [BYTE_W-1:0]   ram_data,
    output logic [BYTE_W-1:0]   byte_q,
    output logic [PIX_BITS-1:0] pix_lo
);
    // Apply the selected load, shift or hold to the held byte.
    always_ff @(posedge clk) begin
        if (!rst_n) byte_q <= '0;
        else begin
            unique case (act)
                PIX_LOAD:  byte_q <= ram_data;
                PIX_SHIFT: byte_q <= byte_q >> PIX_BITS;
                default:   byte_q <= byte_q;
            endcase
        end
    end

    // Present the pixel that is currently in the low bits.
    always_comb pix_lo = byte_q[PIX_BITS-1:0];
endmodule

// File: rtl/vga_stream_gen.sv
// Raster timing and pixel stream generator (top).
// Ties the pixel and line counters to two sync registers. Forms the blank
// condition and delays it one clock. Steps the packed pixel byte on visible
// clocks, loading a new byte from memory at every group of pixels.
// Assumes: H_VIS is a multiple of pixels per byte, and pixels per byte is a
// power of two; synchronous active-low reset applied only at start-up.
module vga_stream_gen
    import vga_pkg::*;
#(
    parameter int H_TOTAL  = 381,
    parameter int H_VIS    = 256,
    parameter int HS_START = 291,
    parameter int HS_END   = 337,
    parameter int V_TOTAL  = 528,
    parameter int V_VIS    = 480,
    parameter int VS_START = 493,
    parameter int VS_END   = 495,
    parameter int BYTE_W   = 8,
    parameter int PIX_BITS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [BYTE_W-1:0]   ram_data,
    output logic                hsync_n,
    output logic                vsync_n,
    output logic                blank,
    output logic [PIX_BITS-1:0] pix_code
);
    localparam int HW    = $clog2(H_TOTAL);
    localparam int VW    = $clog2(V_TOTAL);
    localparam int PPB   = BYTE_W / PIX_BITS;
    localparam int SEL_W = (PPB > 1) ? $clog2(PPB) : 1;

    logic [HW-1:0]       hcnt;
    logic [VW-1:0]       vcnt;
    logic                line_adv;
    logic                h_blank;
    logic                v_blank;
    logic                blank_raw;
    logic                blank_q;
    logic                load_en;
    pix_act_e            pix_act;
    logic [BYTE_W-1:0]   pix_byte;
    logic [PIX_BITS-1:0] pix_lo;

    vga_hcount #(.H_TOTAL(H_TOTAL), .H_VIS(H_VIS), .HW(HW)) u_hcnt (
        .clk(clk), .rst_n(rst_n), .hcnt(hcnt),
        .line_adv(line_adv), .h_blank(h_blank)
    );

    vga_vcount #(.V_TOTAL(V_TOTAL), .V_VIS(V_VIS), .VW(VW)) u_vcnt (
        .clk(clk), .rst_n(rst_n), .line_adv(line_adv),
        .vcnt(vcnt), .v_blank(v_blank)
    );

    vga_sync_reg #(.W(HW), .START(HS_START), .STOP(HS_END)) u_hsync (
        .clk(clk), .rst_n(rst_n), .step_en(1'b1),
        .cnt(hcnt), .sync_n(hsync_n)
    );

    vga_sync_reg #(.W(VW), .START(VS_START), .STOP(VS_END)) u_vsync (
        .clk(clk), .rst_n(rst_n), .step_en(line_adv),
        .cnt(vcnt), .sync_n(vsync_n)
    );

    // Decide whether this clock starts a new group of packed pixels.
    generate
        if (PPB > 1) begin : g_group
            always_comb load_en = ~blank_raw && (hcnt[SEL_W-1:0] == '0);
        end else begin : g_single
            always_comb load_en = ~blank_raw;
        end
    endgenerate

    // Combine the two blank regions and pick the pixel byte action.
    always_comb begin
        blank_raw = h_blank | v_blank;
        if (load_en)         pix_act = PIX_LOAD;
        else if (!blank_raw) pix_act = PIX_SHIFT;
        else                 pix_act = PIX_HOLD;
    end

    // Delay the blank flag one clock to match the colour stage.
    always_ff @(posedge clk) begin
        if (!rst_n) blank_q <= 1'b1;
        else        blank_q <= blank_raw;
    end

    vga_pix_shift #(.BYTE_W(BYTE_W), .PIX_BITS(PIX_BITS)) u_pix (
        .clk(clk), .rst_n(rst_n), .act(pix_act), .ram_data(ram_data),
        .byte_q(pix_byte), .pix_lo(pix_lo)
    );

    // Drive the outputs, holding the pixel code at zero during blanking.
    always_comb begin
        blank    = blank_q;
        pix_code = blank_q ? '0 : pix_lo;
    end
endmodule

// File: rtl/vga_stream_chk.sv
// Property checker for vga_stream_gen, attached with bind below.
// Watches the internal counters, the pixel byte and the outputs.
// Assumes: reset is held for at least two clocks.
module vga_stream_chk #(
    parameter int H_TOTAL = 381,
    parameter int H_VIS   = 256,
    parameter int HS_START = 291,
    parameter int HS_END  = 337,
    parameter int V_VIS   = 480,
    parameter int HW      = 9,
    parameter int VW      = 10,
    parameter int BYTE_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [HW-1:0]     hcnt,
    input logic [VW-1:0]     vcnt,
    input logic              hsync_n,
    input logic              vsync_n,
    input logic              blank,
    input logic [BYTE_W-1:0] ram_data,
    input logic [BYTE_W-1:0] pix_byte,
    input logic              load_en
);
    localparam logic [HW-1:0] C_LAST  = HW'(H_TOTAL - 1);
    localparam logic [HW-1:0] C_VLAST = HW'(H_VIS - 1);
    localparam logic [HW-1:0] C_VEND  = HW'(H_VIS);
    localparam logic [HW-1:0] C_HSS   = HW'(HS_START);
    localparam logic [HW-1:0] C_HSE   = HW'(HS_END);
    localparam logic [VW-1:0] C_VVIS  = VW'(V_VIS);

    // R1
    hcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hcnt <= C_LAST);

    // R1
    hcnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hcnt == C_LAST) |=> (hcnt == '0));

    // R2
    hsync_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hcnt == C_HSS) |=> !hsync_n);

    // R2
    hsync_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hcnt == C_HSE) |=> hsync_n);

    // R3
    line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (vcnt != $past(vcnt))) |-> ($past(hcnt) == C_VLAST));

    // R10
    vsync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(hcnt) != C_VLAST)) |-> $stable(vsync_n));

    // R6
    blank_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (blank == $past((hcnt >= C_VEND) || (vcnt >= C_VVIS))));

    // R8
    byte_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(load_en)) |-> (pix_byte == $past(ram_data)));

    // R7
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (hsync_n && vsync_n && blank && (hcnt == '0)));
endmodule

bind vga_stream_gen vga_stream_chk #(
    .H_TOTAL(H_TOTAL), .H_VIS(H_VIS), .HS_START(HS_START), .HS_END(HS_END),
    .V_VIS(V_VIS), .HW(HW), .VW(VW), .BYTE_W(BYTE_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .vcnt(vcnt),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .blank(blank),
    .ram_data(ram_data), .pix_byte(pix_byte), .load_en(load_en)
);

// File: tb/tb_vga_stream_gen.sv
// Bench: runs a shrunken timing configuration over several whole frames,
// with a mid-run reset, and checks every output on every cycle.
module tb_vga_stream_gen;
    localparam int HT = 20, HV = 8, HSS = 11, HSE = 14;
    localparam int VT = 12, VV = 8, VSS = 9, VSE = 10;
    localparam int NCYC = 4 * HT * VT;
    localparam int RST2 = 2 * HT * VT + 37;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] ram_data = 8'h00;
    logic       hsync_n, vsync_n, blank;
    logic [1:0] pix_code;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    vga_stream_gen #(
        .H_TOTAL(HT), .H_VIS(HV), .HS_START(HSS), .HS_END(HSE),
        .V_TOTAL(VT), .V_VIS(VV), .VS_START(VSS), .VS_END(VSE)
    ) dut (
        .clk(clk), .rst_n(rst_n), .ram_data(ram_data),
        .hsync_n(hsync_n), .vsync_n(vsync_n), .blank(blank), .pix_code(pix_code)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at t=%0t", req, act, exp, $time);
        end
    endtask

    // Reference state, as it stands after the latest rising edge.
    int mh, mv, mhs, mvs, mbq, mbyte;
    // Edge measurements.
    int hs_low, vs_low, last_hfall, last_vfall, prev_hs, prev_vs;
    bit hs_seen, vs_seen;

    initial begin
        mh = 0; mv = 0; mhs = 1; mvs = 1; mbq = 1; mbyte = 0;
        hs_low = 0; vs_low = 0; last_hfall = -1; last_vfall = -1;
        prev_hs = 1; prev_vs = 1; hs_seen = 0; vs_seen = 0;
        for (int i = 0; i < NCYC; i++) begin
            bit r_now;
            int raw, nh, nv, nhs, nvs, nbyte, adv;
            r_now = !(i < 3 || (i >= RST2 && i < RST2 + 3));
            rst_n = r_now;
            ram_data = 8'((i * 37 + 5) ^ (i >> 3));
            // Advance the reference state by one edge.
            if (!r_now) begin
                mh = 0; mv = 0; mhs = 1; mvs = 1; mbq = 1; mbyte = 0;
            end else begin
                raw = (mh >= HV || mv >= VV) ? 1 : 0;                    // R5
                adv = (mh == HV - 1) ? 1 : 0;                            // R3
                nh = (mh == HT - 1) ? 0 : mh + 1;                        // R1
                nv = adv ? ((mv == VT - 1) ? 0 : mv + 1) : mv;
                nhs = (mh >= HSS && mh < HSE) ? 0 : 1;                   // R2
                nvs = adv ? ((mv >= VSS && mv < VSE) ? 0 : 1) : mvs;     // R4 R10
                if (raw == 1)          nbyte = mbyte;                    // R9
                else if (mh % 4 == 0)  nbyte = int'(ram_data);           // R8
                else                   nbyte = mbyte >> 2;
                mh = nh; mv = nv; mhs = nhs; mvs = nvs; mbq = raw; mbyte = nbyte;
            end
            @(negedge clk);
            if (i == 2) begin
                chk("R7 hsync_n in reset", int'(hsync_n), 1);
                chk("R7 vsync_n in reset", int'(vsync_n), 1);
                chk("R7 blank in reset", int'(blank), 1);
                chk("R7 pix_code in reset", int'(pix_code), 0);
            end
            chk("R2 hsync_n", int'(hsync_n), mhs);
            chk("R4 R10 vsync_n", int'(vsync_n), mvs);
            chk("R5 R6 blank", int'(blank), mbq);
            chk("R8 R9 pix_code", int'(pix_code), (mbq == 1) ? 0 : (mbyte & 3));
            // Pulse widths and periods, measured from observed edges.
            if (!r_now) begin
                hs_seen = 0; vs_seen = 0; last_hfall = -1; last_vfall = -1;
            end else begin
                if (prev_hs == 1 && hsync_n == 1'b0) begin
                    if (last_hfall >= 0) chk("R1 line period", i - last_hfall, HT);
                    last_hfall = i; hs_low = 0; hs_seen = 1;
                end
                if (hsync_n == 1'b0) hs_low++;
                if (prev_hs == 0 && hsync_n == 1'b1 && hs_seen)
                    chk("R2 hsync low width", hs_low, HSE - HSS);
                if (prev_vs == 1 && vsync_n == 1'b0) begin
                    if (last_vfall >= 0) chk("R3 frame period", i - last_vfall, HT * VT);
                    last_vfall = i; vs_low = 0; vs_seen = 1;
                end
                if (vsync_n == 1'b0) vs_low++;
                if (prev_vs == 0 && vsync_n == 1'b1 && vs_seen)
                    chk("R4 vsync low width", vs_low, (VSE - VSS) * HT);
            end
            prev_hs = int'(hsync_n);
            prev_vs = int'(vsync_n);
        end
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(4 * (NCYC + 200));
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule